// File: doc/BRIEF.md
# Power Sequencing Controller

This block is the digital sequencer of a power-management chip that supplies an application processor. It is powered down until one of four wake sources fires: the on-key is pressed (input falls), the alarm line rises, the external-on line rises, or a charger appears. The trigger must still be present once a debounce interval has elapsed, otherwise the block returns to power-down. A surviving start-up keeps the host in reset for a fixed interval and then releases it. From that point the host drives two enables. The system enable brings up a high-voltage regulator group, with the I/O regulator first. The power enable brings up a low-voltage group, but only after the high-voltage group is fully on and a minimum gap has passed since the system enable rose.

Once out of reset, the host must write a watchdog bit within a window, and the block shuts down if that write does not arrive. After the write the block is active, and a sleep request can then put every regulator into a setting programmed for it. Battery under-voltage and over-voltage comparator results, the internal power-on reset and the watchdog write all arrive as synchronous digital inputs. Every delay is counted in whole milliseconds from a one-cycle tick strobe and is set by its own parameter.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After `rst_n` and in power-down, `rst_host_n` is 0, `bat_fault` is 1, `sup_fault` is 1, and all enable and high-impedance outputs are 0.
- R2: While `por_i` is 1 the block stays in power-down with `rst_host_n` low, and wake events arriving then are discarded, so the block does not start up even after `por_i` falls while a trigger level remains held.
- R3: Each of four events starts a start-up attempt: a falling edge on `onkey_n`, a rising edge on `alarm_en`, a rising edge on `ext_on` and a rising edge on `chg_det`.
- R4: The source that woke the block is checked once `DEB_MS` ticks have passed. If its level has gone (onkey_n high, the others low), the block returns to power-down.
- R5: During debounce, host reset hold or the watchdog window, `bat_under` or `bat_over` high sends the block to power-down within one cycle.
- R6: `rst_host_n` rises `RST_MS` ticks after debounce completes, and `bat_fault` is 0 from the end of debounce.
- R7: With the host out of reset and `sys_en` high, `hv_en[0]` (the I/O regulator) turns on first and the remaining `hv_en` bits turn on one cycle later.
- R8: The `lv_en` bits turn on only while `pwr_en` is high, all `hv_en` bits are on and at least `GAP_MS` ticks have passed since `sys_en` rose. `lv_en[0]` leads the others by one cycle, and `sup_fault` falls in the cycle in which every regulator is on.
- R9: A one-cycle `wd_kick` within `WDG_MS` ticks of the host reset release makes the block active and keeps it up. Without it, the block returns to power-down after `WDG_MS` ticks.
- R10: When `pwr_en` falls, all `lv_en` bits clear on the next cycle and `sup_fault` rises. With `sys_en` low and the low group off, the non-I/O `hv_en` bits clear one cycle before `hv_en[0]`.
- R11: `sleep_req` is acted on only in the active state and is ignored during the watchdog window. In sleep, regulator k takes field `sleep_cfg[2k+1:2k]` (high group k = 0..NUM_HV-1, then the low group), where 01 means on, 00 means off, and 1x means high-impedance (enable 0, hiz 1). Dropping `sleep_req` restores the earlier enables on the next cycle.
- R12: Once the host is out of reset, `bat_fault` follows `bat_under` with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_ms | input | 1 | One-cycle strobe, once per millisecond |
| por_i | input | 1 | Internal power-on reset asserted |
| onkey_n | input | 1 | On-key, active low |
| alarm_en | input | 1 | Alarm enable from host |
| ext_on | input | 1 | External-on request |
| chg_det | input | 1 | Charger present |
| bat_under | input | 1 | Battery below under-voltage threshold |
| bat_over | input | 1 | Battery above over-voltage threshold |
| sys_en | input | 1 | Host system enable (high-voltage group) |
| pwr_en | input | 1 | Host power enable (low-voltage group) |
| wd_kick | input | 1 | Watchdog bit written, one-cycle strobe |
| sleep_req | input | 1 | Sleep request |
| sleep_cfg | input | 2*(NUM_HV+NUM_LV) | Per-regulator sleep setting |
| rst_host_n | output | 1 | Reset to host, active low |
| bat_fault | output | 1 | Battery fault to host |
| sup_fault | output | 1 | Supply not yet stable |
| hv_en | output | NUM_HV | High-voltage group enables, bit 0 is I/O |
| hv_hiz | output | NUM_HV | High-voltage group high-impedance |
| lv_en | output | NUM_LV | Low-voltage group enables, bit 0 is core |
| lv_hiz | output | NUM_LV | Low-voltage group high-impedance |

## Verification
Deep-sleep shutdown ordering is the hardest state to reach. It needs a full boot, a watchdog write, both groups on and the gap satisfied, and then both enables must drop in the same cycle, so the three-step teardown (low group, high group without I/O, I/O) shows up on consecutive cycles. The bench reaches it by driving the host handshake in order with shortened delay parameters and sampling one cycle apart. The same directed run also places the low-group ordering and the sleep settings where each can be observed.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        S_OFF  = 3'd0,
        S_DEB  = 3'd1,
        S_BOOT = 3'd2,
        S_HOST = 3'd3,
        S_ACT  = 3'd4,
        S_SLP  = 3'd5
    } pseq_state_e;

    localparam int unsigned N_WAKE = 4;

endpackage

// File: rtl/pseq_wake.sv
module pseq_wake
    import pwr_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              onkey_n,
    input  logic              alarm_en,
    input  logic              ext_on,
    input  logic              chg_det,
    output logic [N_WAKE-1:0] wake_pulse,
    output logic [N_WAKE-1:0] wake_level
);
    logic [N_WAKE-1:0] lvl_d, lvl_q;

    always_comb begin
        lvl_d      = {chg_det, ext_on, alarm_en, ~onkey_n};
        wake_level = lvl_d;
        wake_pulse = lvl_d & ~lvl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end
endmodule

// File: rtl/pseq_msctr.sv
module pseq_msctr #(
    parameter int unsigned W   = 8,
    parameter int unsigned MAX = 100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] LIMIT = W'(MAX);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                        cnt_d = '0;
        else if (tick && cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int unsigned NUM_HV = 3,
    parameter int unsigned NUM_LV = 3,
    parameter int unsigned DEB_MS = 32,
    parameter int unsigned RST_MS = 50,
    parameter int unsigned GAP_MS = 125,
    parameter int unsigned WDG_MS = 8000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick_ms,
    input  logic                         por_i,
    input  logic                         onkey_n,
    input  logic                         alarm_en,
    input  logic                         ext_on,
    input  logic                         chg_det,
    input  logic                         bat_under,
    input  logic                         bat_over,
    input  logic                         sys_en,
    input  logic                         pwr_en,
    input  logic                         wd_kick,
    input  logic                         sleep_req,
    input  logic [2*(NUM_HV+NUM_LV)-1:0] sleep_cfg,
    output logic                         rst_host_n,
    output logic                         bat_fault,
    output logic                         sup_fault,
    output logic [NUM_HV-1:0]            hv_en,
    output logic [NUM_HV-1:0]            hv_hiz,
    output logic [NUM_LV-1:0]            lv_en,
    output logic [NUM_LV-1:0]            lv_hiz
);
    localparam int unsigned NUM_REG = NUM_HV + NUM_LV;
    localparam int unsigned MAX_A   = (DEB_MS > RST_MS) ? DEB_MS : RST_MS;
    localparam int unsigned MAX_MS  = (WDG_MS > MAX_A) ? WDG_MS : MAX_A;
    localparam int unsigned CNT_W   = $clog2(MAX_MS + 1);
    localparam int unsigned GAP_W   = $clog2(GAP_MS + 1);
    localparam logic [CNT_W-1:0] DEB_C = CNT_W'(DEB_MS);
    localparam logic [CNT_W-1:0] RST_C = CNT_W'(RST_MS);
    localparam logic [CNT_W-1:0] WDG_C = CNT_W'(WDG_MS);
    localparam logic [GAP_W-1:0] GAP_C = GAP_W'(GAP_MS);

    typedef struct packed {
        pseq_state_e       st;
        logic [N_WAKE-1:0] src;
        logic [NUM_HV-1:0] hv;
        logic [NUM_LV-1:0] lv;
        logic              rst_n;
        logic              bat_f;
        logic              sup_f;
    } pseq_regs_t;

    localparam pseq_regs_t REGS_RST = '{
        st: S_OFF, src: '0, hv: '0, lv: '0,
        rst_n: 1'b0, bat_f: 1'b1, sup_f: 1'b1
    };

    pseq_regs_t        r_d, r_q;
    pseq_state_e       st_q;
    logic [N_WAKE-1:0] wake_pulse, wake_level;
    logic [CNT_W-1:0]  tcnt;
    logic [GAP_W-1:0]  gcnt;
    logic              tmr_clr, bat_bad, gap_done, do_seq;
    logic [NUM_REG-1:0] cfg_on, cfg_hiz;

    pseq_wake u_wake (
        .clk(clk), .rst_n(rst_n),
        .onkey_n(onkey_n), .alarm_en(alarm_en), .ext_on(ext_on), .chg_det(chg_det),
        .wake_pulse(wake_pulse), .wake_level(wake_level)
    );

    pseq_msctr #(.W(CNT_W), .MAX(MAX_MS)) u_state_tmr (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick_ms), .cnt(tcnt)
    );

    pseq_msctr #(.W(GAP_W), .MAX(GAP_MS)) u_gap_tmr (
        .clk(clk), .rst_n(rst_n), .clr(~sys_en), .tick(tick_ms), .cnt(gcnt)
    );

    // per-regulator sleep field decode: 01 on, 00 off, 1x high impedance
    for (genvar k = 0; k < NUM_REG; k++) begin : g_cfg
        assign cfg_on[k]  = (sleep_cfg[2*k+1 -: 2] == 2'b01);
        assign cfg_hiz[k] = sleep_cfg[2*k+1];
    end

    assign bat_bad  = bat_under | bat_over;
    assign gap_done = (gcnt == GAP_C);
    assign st_q     = r_q.st;

    always_comb begin
        r_d    = r_q;
        do_seq = 1'b0;
        case (r_q.st)
            S_OFF: begin
                if (|wake_pulse) begin
                    r_d.st  = S_DEB;
                    r_d.src = wake_pulse;
                end
            end
            S_DEB: begin
                if (bat_bad) r_d = REGS_RST;
                else if (tcnt >= DEB_C) begin
                    if (|(r_q.src & wake_level)) begin
                        r_d.st    = S_BOOT;
                        r_d.bat_f = bat_under;
                    end else begin
                        r_d = REGS_RST;
                    end
                end
            end
            S_BOOT: begin
                if (bat_bad) r_d = REGS_RST;
                else if (tcnt >= RST_C) begin
                    r_d.st    = S_HOST;
                    r_d.rst_n = 1'b1;
                end
            end
            S_HOST: begin
                if (bat_bad || tcnt >= WDG_C) r_d = REGS_RST;
                else begin
                    do_seq    = 1'b1;
                    r_d.bat_f = bat_under;
                    if (wd_kick) r_d.st = S_ACT;
                end
            end
            S_ACT: begin
                r_d.bat_f = bat_under;
                if (sleep_req) r_d.st = S_SLP;
                else           do_seq = 1'b1;
            end
            S_SLP: begin
                r_d.bat_f = bat_under;
                if (!sleep_req) r_d.st = S_ACT;
            end
            default: r_d = REGS_RST;
        endcase

        if (do_seq) begin
            // high group: I/O regulator leads on the way up, trails on the way down
            if (sys_en) begin
                if (!r_q.hv[0]) r_d.hv[0] = 1'b1;
                else            r_d.hv    = '1;
            end else if (r_q.lv == '0) begin
                if (|r_q.hv[NUM_HV-1:1]) r_d.hv[NUM_HV-1:1] = '0;
                else                     r_d.hv[0]          = 1'b0;
            end
            // low group: needs full high group and the enable gap
            if (!pwr_en) r_d.lv = '0;
            else if (gap_done && (&r_q.hv)) begin
                if (!r_q.lv[0]) r_d.lv[0] = 1'b1;
                else            r_d.lv    = '1;
            end
            r_d.sup_f = ~((&r_d.hv) & (&r_d.lv));
        end

        if (por_i) r_d = REGS_RST;
        tmr_clr = (r_d.st != r_q.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign rst_host_n = r_q.rst_n;
    assign bat_fault  = r_q.bat_f;
    assign sup_fault  = r_q.sup_f;
    assign hv_en  = (st_q == S_SLP) ? cfg_on[NUM_HV-1:0]        : r_q.hv;
    assign hv_hiz = (st_q == S_SLP) ? cfg_hiz[NUM_HV-1:0]       : '0;
    assign lv_en  = (st_q == S_SLP) ? cfg_on[NUM_REG-1:NUM_HV]  : r_q.lv;
    assign lv_hiz = (st_q == S_SLP) ? cfg_hiz[NUM_REG-1:NUM_HV] : '0;
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk
    import pwr_seq_pkg::*;
#(
    parameter int unsigned NUM_HV = 3,
    parameter int unsigned NUM_LV = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por_i,
    input logic              rst_host_n,
    input logic              sup_fault,
    input logic [NUM_HV-1:0] hv_en,
    input logic [NUM_LV-1:0] lv_en,
    input pseq_state_e       st_q
);
    p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_OFF) |-> (hv_en == '0 && lv_en == '0 && !rst_host_n));

    p_por_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        por_i |=> (st_q == S_OFF && !rst_host_n));

    p_release_in_host_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_host_n) |-> (st_q == S_HOST));

    p_io_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_SLP && |hv_en[NUM_HV-1:1]) |-> hv_en[0]);

    p_lv_after_hv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_SLP && |lv_en) |-> (&hv_en));

    p_sup_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == S_HOST || st_q == S_ACT) && !sup_fault) |-> ((&hv_en) && (&lv_en)));

    p_io_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_ACT && $past(st_q) == S_ACT && $fell(hv_en[0]))
            |-> ($past(hv_en[NUM_HV-1:1]) == '0));
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(.NUM_HV(NUM_HV), .NUM_LV(NUM_LV)) u_chk (
    .clk(clk), .rst_n(rst_n), .por_i(por_i), .rst_host_n(rst_host_n),
    .sup_fault(sup_fault), .hv_en(hv_en), .lv_en(lv_en), .st_q(st_q)
);

// File: tb/pwr_seq_ctrl_tb.sv
`timescale 1ns/100ps
module pwr_seq_ctrl_tb;
    localparam int NHV = 3;
    localparam int NLV = 3;
    localparam int MSC = 4;     // clock cycles per millisecond tick

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ms = 1'b0;
    logic por_i = 1'b0, onkey_n = 1'b1, alarm_en = 1'b0, ext_on = 1'b0, chg_det = 1'b0;
    logic bat_under = 1'b0, bat_over = 1'b0, sys_en = 1'b0, pwr_en = 1'b0;
    logic wd_kick = 1'b0, sleep_req = 1'b0;
    logic [2*(NHV+NLV)-1:0] sleep_cfg = '0;
    logic rst_host_n, bat_fault, sup_fault;
    logic [NHV-1:0] hv_en, hv_hiz;
    logic [NLV-1:0] lv_en, lv_hiz;
    logic [1:0] div = '0;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        div     <= div + 2'd1;
        tick_ms <= (div == 2'd3);
    end

    pwr_seq_ctrl #(.NUM_HV(NHV), .NUM_LV(NLV), .DEB_MS(4), .RST_MS(6),
                   .GAP_MS(5), .WDG_MS(20)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .por_i(por_i),
        .onkey_n(onkey_n), .alarm_en(alarm_en), .ext_on(ext_on), .chg_det(chg_det),
        .bat_under(bat_under), .bat_over(bat_over), .sys_en(sys_en), .pwr_en(pwr_en),
        .wd_kick(wd_kick), .sleep_req(sleep_req), .sleep_cfg(sleep_cfg),
        .rst_host_n(rst_host_n), .bat_fault(bat_fault), .sup_fault(sup_fault),
        .hv_en(hv_en), .hv_hiz(hv_hiz), .lv_en(lv_en), .lv_hiz(lv_hiz)
    );

    // rows: [7:6] wake source (0 onkey,1 alarm,2 ext,3 charger), [5:1] hold ms, [0] expect boot
    localparam logic [7:0] VEC [0:7] = '{
        {2'd0, 5'd12, 1'b1}, {2'd0, 5'd2, 1'b0},
        {2'd1, 5'd12, 1'b1}, {2'd1, 5'd2, 1'b0},
        {2'd2, 5'd12, 1'b1}, {2'd2, 5'd2, 1'b0},
        {2'd3, 5'd12, 1'b1}, {2'd3, 5'd2, 1'b0}
    };

    task automatic step(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_ms(int n);
        step(n * MSC);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_src(int s, bit v);
        case (s)
            0: onkey_n  = ~v;
            1: alarm_en = v;
            2: ext_on   = v;
            default: chg_det = v;
        endcase
    endtask

    task automatic fresh();
        rst_n = 1'b0;
        por_i = 1'b0; onkey_n = 1'b1; alarm_en = 1'b0; ext_on = 1'b0; chg_det = 1'b0;
        bat_under = 1'b0; bat_over = 1'b0; sys_en = 1'b0; pwr_en = 1'b0;
        wd_kick = 1'b0; sleep_req = 1'b0; sleep_cfg = '0;
        step(3);
        rst_n = 1'b1;
        step(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        fresh();
        // R1 reset state
        check("R1 rst_host_n", rst_host_n, 0);
        check("R1 bat_fault", bat_fault, 1);
        check("R1 sup_fault", sup_fault, 1);
        check("R1 enables", {hv_en, lv_en, hv_hiz, lv_hiz}, 0);

        // R3 R4 table: each wake source, held versus released early
        for (int i = 0; i < 8; i++) begin
            fresh();
            set_src(int'(VEC[i][7:6]), 1'b1);
            wait_ms(int'(VEC[i][5:1]));
            set_src(int'(VEC[i][7:6]), 1'b0);
            wait_ms(14 - int'(VEC[i][5:1]));
            check(VEC[i][0] ? "R3 wake boot" : "R4 debounce reject",
                  rst_host_n, VEC[i][0]);
        end

        // R2 power-on reset blocks wake
        fresh();
        por_i = 1'b1;
        onkey_n = 1'b0;
        wait_ms(14);
        check("R2 por hold", rst_host_n, 0);
        por_i = 1'b0;
        wait_ms(14);
        check("R2 event discarded", rst_host_n, 0);
        onkey_n = 1'b1;

        // R5 over-voltage during host reset hold
        fresh();
        onkey_n = 1'b0;
        wait_ms(6);
        bat_over = 1'b1;
        wait_ms(1);
        bat_over = 1'b0;
        wait_ms(7);
        check("R5 abort rst", rst_host_n, 0);
        check("R5 abort batf", bat_fault, 1);
        onkey_n = 1'b1;

        // R6 R9 R11: boot, sleep ignored in window, no kick -> shutdown
        fresh();
        onkey_n = 1'b0;
        wait_ms(8);
        check("R6 still in reset", rst_host_n, 0);
        wait_ms(6);
        onkey_n = 1'b1;
        check("R6 released", rst_host_n, 1);
        check("R6 bat_fault low", bat_fault, 0);
        sleep_cfg = '1;
        sleep_req = 1'b1;
        step(2);
        check("R11 ignored in window", {hv_en, hv_hiz, lv_en, lv_hiz}, 0);
        sleep_req = 1'b0;
        sleep_cfg = '0;
        wait_ms(26);
        check("R9 timeout", rst_host_n, 0);

        // main handshake
        fresh();
        onkey_n = 1'b0;
        wait_ms(14);
        onkey_n = 1'b1;
        sys_en = 1'b1;
        step();
        check("R7 io first", hv_en, 3'b001);
        step();
        check("R7 rest", hv_en, 3'b111);
        pwr_en = 1'b1;
        wait_ms(2);
        check("R8 gap hold", lv_en, 0);
        wait_ms(6);
        check("R8 lv on", lv_en, 3'b111);
        check("R8 sup ok", sup_fault, 0);
        pwr_en = 1'b0;
        step();
        check("R10 lv off", lv_en, 0);
        check("R10 sup fault", sup_fault, 1);
        pwr_en = 1'b1;
        step();
        check("R8 core first", lv_en, 3'b001);
        step();
        check("R8 lv rest", lv_en, 3'b111);
        wd_kick = 1'b1;
        step();
        wd_kick = 1'b0;
        wait_ms(25);
        check("R9 kicked stays", rst_host_n, 1);

        // R11 sleep settings: hv0 on, hv1 off, hv2 hiz, lv0 hiz, lv1 on, lv2 off
        sleep_cfg = 12'h1A1;
        sleep_req = 1'b1;
        step();
        check("R11 sleep hv_en", hv_en, 3'b001);
        check("R11 sleep hv_hiz", hv_hiz, 3'b100);
        check("R11 sleep lv_en", lv_en, 3'b010);
        check("R11 sleep lv_hiz", lv_hiz, 3'b001);
        sleep_req = 1'b0;
        step();
        check("R11 restore", {hv_en, lv_en, hv_hiz, lv_hiz}, 12'b111_111_000_000);

        // R12 battery fault follows comparator
        bat_under = 1'b1;
        step();
        check("R12 bat_fault set", bat_fault, 1);
        bat_under = 1'b0;
        step();
        check("R12 bat_fault clear", bat_fault, 0);

        // R10 deep sleep ordering and exit
        pwr_en = 1'b0;
        sys_en = 1'b0;
        step();
        check("R10 step1", {hv_en, lv_en}, 6'b111_000);
        step();
        check("R10 step2", hv_en, 3'b001);
        step();
        check("R10 step3", hv_en, 3'b000);
        sys_en = 1'b1;
        step();
        check("R7 exit io first", hv_en, 3'b001);
        step();
        check("R7 exit rest", hv_en, 3'b111);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule